// File: doc/BRIEF.md
# Three-Bit XOR Feedback Sequencer

This block holds a three-bit state and, on every clock edge where its step enable is high, advances that state along a fixed cycle of seven values. Each step moves the low bit into the middle bit and the middle bit into the high bit. The new low bit is the XOR of the old high and middle bits. The state is read as an unsigned number, with bit 2 weighted four, bit 1 weighted two and bit 0 weighted one. Starting from 1, the cycle visits 1, 2, 5, 3, 7, 6 and 4, and then returns to 1.

A synchronous reset loads a start value, which is 1 by default. A registered pulse marks each return from 4 to 1, so a consumer can count full laps of the cycle. XOR feedback on its own would leave the all-zero value stuck at zero. A zero detector in the next-state path therefore sends any zero state to 1 on the next enabled step. That zero value can only be reached by choosing a start value of 0.

Top module: `xseq_stepper`

## Requirements
- R1: While reset is high at a rising edge, the state is loaded with the start value (default 1, so bit 0 = 1 and bits 2 and 1 = 0), and the wrap pulse is 0 after that edge.
- R2: The state output is read as 4·bit2 + 2·bit1 + bit0; bit 0 of the port is the low weight.
- R3: Starting at 1, successive enabled steps give 1, 2, 5, 3, 7, 6, 4, and then 1 again, repeating without end.
- R4: At a rising edge where step enable is low and reset is low, the state and the wrap pulse do not advance: the state holds, and the wrap pulse is 0 after that edge.
- R5: An enabled step taken from state 0 gives state 1.
- R6: The wrap pulse is 1 for exactly the one cycle after an enabled step that moves the state from 4 to 1, and it is 0 in every other cycle.
- R7: Once the state is non-zero it never becomes 0, and exactly seven enabled steps bring it back to any value it holds.
- R8: On each enabled step from a non-zero state, the new bit 1 equals the old bit 0, the new bit 2 equals the old bit 1, and the new bit 0 equals the old bit 2 XOR the old bit 1.
- R9: Reset takes priority over step enable: with both high, the start value is loaded.
- R10: The start value is a parameter. A start value of 0 is allowed, and reset then holds the state at 0 until the first enabled step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the state at this edge when high |
| q_o | output | 3 | Current state, bit 0 least significant |
| wrap_o | output | 1 | One-cycle pulse after the step from 4 to 1 |

## Verification
The bench interleaves idle cycles with enabled steps. An enable that is decoded wrongly would show up as a skipped or extra value in the walked sequence. It also checks that the wrap pulse drops while the state stays at 1 with enable low. A design that derived the pulse from the state alone would keep it high there. A second instance starts at 0 and is expected to move to 1 on its first step. A design without zero recovery would stay locked at 0. Reset is also applied with enable held high, which catches a design that gives the step priority over reset. Finally, a long run counts laps and checks the shift-and-XOR relation between every pair of consecutive states.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
   localparam int unsigned SEQ_W     = 3;
   localparam int unsigned SEQ_LEN   = 7;
   localparam int unsigned SEQ_START = 1;
   localparam int unsigned SEQ_LAST  = 4;
endpackage

// File: rtl/xseq_next.sv
module xseq_next #(
   parameter int unsigned W = xseq_pkg::SEQ_W
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] shifted;
   logic         feedback;
   logic         is_zero;

   assign feedback   = cur[W-1] ^ cur[W-2];
   assign shifted[0] = feedback;

   generate
      for (genvar i = 1; i < W; i++) begin : g_shift
         assign shifted[i] = cur[i-1];
      end
   endgenerate

   assign is_zero = (cur == '0);

   always_comb begin
      if (is_zero) nxt = ONE;
      else         nxt = shifted;
   end
endmodule

// File: rtl/xseq_reg.sv
module xseq_reg #(
   parameter int unsigned W     = xseq_pkg::SEQ_W,
   parameter int unsigned START = xseq_pkg::SEQ_START
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] START_V = W'(START);

   always_ff @(posedge clk) begin
      if (rst)     q <= START_V;
      else if (en) q <= d;
   end

   // R1 and R9: reset loads the start value, whatever the enable does
   a_r1_reset_load: assert property (@(posedge clk) rst |=> (q == START_V));
   a_r9_reset_wins: assert property (@(posedge clk) (rst && en) |=> (q == START_V));
   // R4: no enable, no change
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(q));
endmodule

// File: rtl/xseq_wrap.sv
module xseq_wrap #(
   parameter int unsigned W    = xseq_pkg::SEQ_W,
   parameter int unsigned LAST = xseq_pkg::SEQ_LAST
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] cur,
   output logic         wrap
);
   localparam logic [W-1:0] LAST_V = W'(LAST);

   always_ff @(posedge clk) begin
      if (rst) wrap <= 1'b0;
      else     wrap <= en && (cur == LAST_V);
   end

   // R6: the pulse follows the step out of the last state and lasts one cycle
   a_r6_on_last: assert property (@(posedge clk) disable iff (rst)
      (en && cur == LAST_V) |=> wrap);
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
      wrap |=> !wrap);
   a_r1_wrap_clear: assert property (@(posedge clk) rst |=> !wrap);
endmodule

// File: rtl/xseq_stepper.sv
module xseq_stepper #(
   parameter int unsigned STATE_W     = xseq_pkg::SEQ_W,
   parameter int unsigned START_VALUE = xseq_pkg::SEQ_START
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_en,
   output logic [STATE_W-1:0] q_o,
   output logic               wrap_o
);
   localparam logic [STATE_W-1:0] ONE_V = {{(STATE_W-1){1'b0}}, 1'b1};

   generate
      if (STATE_W != 3) begin : g_bad_width
         $error("xseq_stepper: feedback is defined for a three-bit state only");
      end
      if (START_VALUE >= (1 << STATE_W)) begin : g_bad_start
         $error("xseq_stepper: start value does not fit the state");
      end
   endgenerate

   logic [STATE_W-1:0] state;
   logic [STATE_W-1:0] state_nxt;

   xseq_next #(.W(STATE_W)) u_next (
      .cur (state),
      .nxt (state_nxt)
   );

   xseq_reg #(.W(STATE_W), .START(START_VALUE)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (step_en),
      .d   (state_nxt),
      .q   (state)
   );

   xseq_wrap #(.W(STATE_W), .LAST(xseq_pkg::SEQ_LAST)) u_wrap (
      .clk  (clk),
      .rst  (rst),
      .en   (step_en),
      .cur  (state),
      .wrap (wrap_o)
   );

   assign q_o = state;

   // R5: zero recovers to one
   a_r5_zero_exit: assert property (@(posedge clk) disable iff (rst)
      (step_en && state == '0) |=> (state == ONE_V));
   // R8: shift and XOR relation between consecutive states
   a_r8_shift_xor: assert property (@(posedge clk) disable iff (rst)
      (step_en && state != '0) |=>
         (state[1] == $past(state[0])) && (state[2] == $past(state[1])) &&
         (state[0] == ($past(state[2]) ^ $past(state[1]))));
   // R7: a non-zero state stays non-zero
   a_r7_no_zero: assert property (@(posedge clk) disable iff (rst)
      (state != '0) |=> (state != '0));
   // R6: the pulse is seen only while the state is the first one
   a_r6_at_first: assert property (@(posedge clk) disable iff (rst)
      wrap_o |-> (state == ONE_V));
endmodule

// File: tb/xseq_stepper_tb.sv
`timescale 1ns/1ps
module xseq_stepper_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step_en = 1'b0;
   logic en_z = 1'b0;
   logic [2:0] q_o, q_z;
   logic wrap_o, wrap_z;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   xseq_stepper u_dut (.clk(clk), .rst(rst), .step_en(step_en), .q_o(q_o), .wrap_o(wrap_o));
   xseq_stepper #(.START_VALUE(0)) u_zero (.clk(clk), .rst(rst), .step_en(en_z), .q_o(q_z), .wrap_o(wrap_z));

   // {enable, expected state, expected wrap} after each edge, from state 1
   localparam int NVEC = 18;
   localparam logic [4:0] VEC [NVEC] = '{
      {1'b1, 3'd2, 1'b0}, {1'b1, 3'd5, 1'b0}, {1'b0, 3'd5, 1'b0},
      {1'b1, 3'd3, 1'b0}, {1'b1, 3'd7, 1'b0}, {1'b1, 3'd6, 1'b0},
      {1'b0, 3'd6, 1'b0}, {1'b1, 3'd4, 1'b0}, {1'b1, 3'd1, 1'b1},
      {1'b0, 3'd1, 1'b0}, {1'b1, 3'd2, 1'b0}, {1'b1, 3'd5, 1'b0},
      {1'b1, 3'd3, 1'b0}, {1'b1, 3'd7, 1'b0}, {1'b1, 3'd6, 1'b0},
      {1'b1, 3'd4, 1'b0}, {1'b1, 3'd1, 1'b1}, {1'b1, 3'd2, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input logic e, input logic ez);
      @(negedge clk);
      step_en = e;
      en_z = ez;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      chk("R1 reset state", int'(q_o), 1);
      chk("R1 reset wrap", int'(wrap_o), 0);
      chk("R10 zero start", int'(q_z), 0);
      @(negedge clk) rst = 1'b0;

      // R2 R3 R4 R6 table walk
      for (int i = 0; i < NVEC; i++) begin
         tick(VEC[i][4], 1'b0);
         chk("R3 R2 R4 state", int'(q_o), int'(VEC[i][3:1]));
         chk("R6 wrap", int'(wrap_o), int'(VEC[i][0]));
      end
      // R2 bit weights: state 2 has only bit 1 set
      chk("R2 bit1", int'(q_o[1]), 1);
      chk("R2 bit0", int'(q_o[0]), 0);

      // R9: reset with enable high loads the start value
      @(negedge clk) begin rst = 1'b1; step_en = 1'b1; end
      @(posedge clk); #1;
      chk("R9 reset priority", int'(q_o), 1);
      @(negedge clk) begin rst = 1'b0; step_en = 1'b0; end

      // R4 and R10: zero instance holds at zero without enable
      tick(1'b0, 1'b0);
      chk("R4 R10 zero hold", int'(q_z), 0);
      // R5: first step from zero gives one
      tick(1'b0, 1'b1);
      chk("R5 zero exit", int'(q_z), 1);
      chk("R5 no wrap from zero", int'(wrap_z), 0);

      // R7 R8 long run on the main instance
      begin
         logic [2:0] prev;
         int wraps = 0;
         int lap = 0;
         int first_ret = 0;
         prev = q_o;
         for (int s = 1; s <= 70; s++) begin
            tick(1'b1, 1'b1);
            if (wrap_o) wraps++;
            chk("R8 bit1", int'(q_o[1]), int'(prev[0]));
            chk("R8 bit2", int'(q_o[2]), int'(prev[1]));
            chk("R8 bit0", int'(q_o[0]), int'(prev[2] ^ prev[1]));
            chk("R7 nonzero", int'(q_o != 3'd0), 1);
            chk("R7 zero instance nonzero", int'(q_z != 3'd0), 1);
            if (q_o == 3'd1 && first_ret == 0) first_ret = s;
            lap++;
            prev = q_o;
         end
         chk("R7 period", first_ret, 7);
         chk("R6 wrap count", wraps, 10);
         chk("R7 steps", lap, 70);
      end
      finish_run();
   end
endmodule